// File: doc/BRIEF.md
# Event Timer Global Registers and Main Counter

This block is the shared front end of a multi-channel event timer. It owns the 64-bit main counter, the read-only capability word, the global configuration (run enable and legacy routing) and the channel interrupt status register. It decodes a 1 KB register window over a bus that only carries 32-bit words. It also forwards every access that lands in a channel's slot to the channel array, together with the channel number and the offset of the register inside the slot.

The counter advances by one on each cycle where `tick_en` is high, but only while the run enable is set. Software can read it at any time, and can write it as two 32-bit halves at any time. A write while the counter runs is accepted, and the block reports it as a questionable access.

Changes of the run enable are passed to the channels as single-cycle pulses. A rising edge tells the channels to re-arm; each channel decides this from its own comparator. A falling edge makes every channel drop its interrupt, and it also empties the status register. Channels report events as pulses on `ch_evt`. Software clears status bits by writing ones to them.

Top module: `evt_timer_core`

## Requirements
- R1: After reset, the counter halves, the general configuration and the status register all read zero, and no pulse output is high.
- R2: While the run enable (general config bit 0) is set, the counter increases by exactly one on each clock where `tick_en` is high, and the carry passes from the low word into the high word. While the run enable is clear, the counter holds its value whatever `tick_en` does.
- R3: Writes to the counter low word (0x0F0) and high word (0x0F4) replace only that half, and they take precedence over a tick in the same cycle. A counter write made while the run enable is set raises `cnt_wr_live` in the following cycle. A counter write made while the run enable is clear leaves `cnt_wr_live` low.
- R4: The capability low word (0x000) reads as follows: bits 7:0 = 0x01, bits 12:8 = channel count minus one, bit 13 = 1 (64-bit counter), bit 14 = 0, bit 15 = 1 (legacy routing capable), bits 31:16 = 0x5A17. The capability high word (0x004) reads as the tick period in femtoseconds. Writes to both words have no effect.
- R5: In the general config (0x010), only bit 0 (run enable) and bit 1 (legacy route) can be written, and every other bit reads zero. Word 0x014 reads zero and ignores writes.
- R6: A write that changes the run enable from 0 to 1 gives a one-cycle `arm_all` pulse in the next cycle. A change from 1 to 0 gives a one-cycle `disarm_all` pulse in the next cycle, and the status register is cleared at that point.
- R7: Status (0x020, bit n = channel n) sets bit n when `ch_evt[n]` is high while the run enable is set. Events that arrive while the run enable is clear are dropped. A status write clears only the bits that are written as 1 and are currently set. In the next cycle, `status_clr` pulses exactly those bits.
- R8: An access at 0x100 + 0x20·n + k, for n below the channel count, drives `ch_req` high with `ch_idx` = n, `ch_off` = k and `ch_wr` equal to the bus write flag. A read of that address returns `ch_rdata`.
- R9: An access to a channel slot whose number is at or above the channel count reads zero and never raises `ch_req`.
- R10: Any other address in the window reads zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick qualifier |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational for the current access |
| ch_req | output | 1 | Access forwarded to a channel |
| ch_wr | output | 1 | Forwarded access is a write |
| ch_idx | output | 5 | Channel number of the forwarded access |
| ch_off | output | 5 | Byte offset within the channel slot |
| ch_wdata | output | 32 | Forwarded write data |
| ch_rdata | input | 32 | Read data returned by the addressed channel |
| ch_evt | input | NCH | Per-channel event pulses |
| status_clr | output | NCH | Per-channel interrupt clear pulses |
| arm_all | output | 1 | Run enable rose: channels re-arm |
| disarm_all | output | 1 | Run enable fell: channels drop interrupts |
| glb_en | output | 1 | Run enable |
| legacy_en | output | 1 | Legacy route enable |
| count | output | 64 | Main counter value |
| cnt_wr_live | output | 1 | Counter was written while running |

## Verification
Two cases are hard to reach from the ports. The first is a counter write that lands in the same cycle as a tick. The bench holds `tick_en` high while it writes the low word of a running counter, then reads the value back before the next edge. The second is a status clear aimed at a mix of set and unset bits. The bench first sets a known pattern by pulsing `ch_evt` with the counter enabled, then writes a mask that covers one set bit and one clear bit. It then checks the clear pulse and the read-back for exactly the overlap. A counter preloaded just below a 32-bit boundary exposes the carry into the high word after a counted number of ticks.

// File: rtl/etc_pkg.sv
package etc_pkg;

  localparam logic [9:0] A_CAP_LO = 10'h000;
  localparam logic [9:0] A_CAP_HI = 10'h004;
  localparam logic [9:0] A_CFG    = 10'h010;
  localparam logic [9:0] A_STAT   = 10'h020;
  localparam logic [9:0] A_CNT_LO = 10'h0F0;
  localparam logic [9:0] A_CNT_HI = 10'h0F4;
  localparam logic [9:0] A_CH_BASE = 10'h100;

  localparam logic [1:0] CFG_WMASK = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP_LO, SEL_CAP_HI, SEL_CFG,
    SEL_STAT, SEL_CNT_LO, SEL_CNT_HI, SEL_CHAN
  } reg_sel_e;

  // next counter value: write of a half wins over a tick
  function automatic logic [63:0] cnt_next(input logic [63:0] cur,
                                           input logic wr_lo, input logic wr_hi,
                                           input logic [31:0] wd, input logic step);
    if (wr_lo)      return {cur[63:32], wd};
    else if (wr_hi) return {wd, cur[31:0]};
    else if (step)  return cur + 64'd1;
    else            return cur;
  endfunction

  // bits actually cleared by a write-one-to-clear
  function automatic logic [31:0] w1c_hits(input logic [31:0] cur, input logic [31:0] wd);
    return cur & wd;
  endfunction

endpackage

// File: rtl/etc_decode.sv
module etc_decode
  import etc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic             bus_sel,
  input  logic [9:0]       bus_addr,
  output reg_sel_e         sel,
  output logic [4:0]       idx,
  output logic [4:0]       off
);
  logic [9:0] rel;

  always_comb begin
    rel = bus_addr - A_CH_BASE;
    idx = rel[9:5];
    off = rel[4:0];
    sel = SEL_NONE;
    if (bus_sel) begin
      if (bus_addr >= A_CH_BASE) begin
        if (int'(idx) < NCH) sel = SEL_CHAN;
      end else begin
        case (bus_addr)
          A_CAP_LO: sel = SEL_CAP_LO;
          A_CAP_HI: sel = SEL_CAP_HI;
          A_CFG:    sel = SEL_CFG;
          A_STAT:   sel = SEL_STAT;
          A_CNT_LO: sel = SEL_CNT_LO;
          A_CNT_HI: sel = SEL_CNT_HI;
          default:  sel = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/etc_counter.sv
module etc_counter
  import etc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        tick_en,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= cnt_next(value, wr_lo, wr_hi, wdata, run && tick_en);
  end
endmodule

// File: rtl/etc_status.sv
module etc_status
  import etc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           flush,
  input  logic [NCH-1:0] evt,
  input  logic           wr,
  input  logic [31:0]    wdata,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] clr_pulse
);
  logic [31:0]    hits_w;
  logic [NCH-1:0] hits;

  always_comb begin
    hits_w = w1c_hits(32'(status), wdata);
    hits   = wr ? hits_w[NCH-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status    <= '0;
      clr_pulse <= '0;
    end else begin
      clr_pulse <= hits;
      if (flush) status <= '0;
      else       status <= (status & ~hits) | (en ? evt : '0);
    end
  end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import etc_pkg::*;
#(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd8_000_000,
  parameter logic [15:0] VENDOR    = 16'h5A17,
  parameter logic [7:0]  REV       = 8'h01
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [9:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           ch_req,
  output logic           ch_wr,
  output logic [4:0]     ch_idx,
  output logic [4:0]     ch_off,
  output logic [31:0]    ch_wdata,
  input  logic [31:0]    ch_rdata,
  input  logic [NCH-1:0] ch_evt,
  output logic [NCH-1:0] status_clr,
  output logic           arm_all,
  output logic           disarm_all,
  output logic           glb_en,
  output logic           legacy_en,
  output logic [63:0]    count,
  output logic           cnt_wr_live
);
  localparam logic [4:0]  NCH_M1 = 5'(NCH - 1);
  localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1, NCH_M1, REV};

  reg_sel_e       sel;
  logic [1:0]     cfg_q;
  logic [1:0]     cfg_d;
  logic [NCH-1:0] status_q;
  logic           cfg_wr, stat_wr, cnt_wr_lo, cnt_wr_hi, cnt_wr_any;
  logic           en_rise, en_fall;

  etc_decode #(.NCH(NCH)) u_dec (
    .bus_sel(bus_sel), .bus_addr(bus_addr), .sel(sel), .idx(ch_idx), .off(ch_off)
  );

  assign cfg_wr     = bus_wr && (sel == SEL_CFG);
  assign stat_wr    = bus_wr && (sel == SEL_STAT);
  assign cnt_wr_lo  = bus_wr && (sel == SEL_CNT_LO);
  assign cnt_wr_hi  = bus_wr && (sel == SEL_CNT_HI);
  assign cnt_wr_any = cnt_wr_lo || cnt_wr_hi;
  assign ch_req     = (sel == SEL_CHAN);
  assign ch_wr      = ch_req && bus_wr;
  assign ch_wdata   = bus_wdata;

  assign cfg_d   = (bus_wdata[1:0] & CFG_WMASK) | (cfg_q & ~CFG_WMASK);
  assign en_rise = cfg_wr && cfg_d[0] && !cfg_q[0];
  assign en_fall = cfg_wr && !cfg_d[0] && cfg_q[0];
  assign glb_en    = cfg_q[0];
  assign legacy_en = cfg_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      arm_all     <= 1'b0;
      disarm_all  <= 1'b0;
      cnt_wr_live <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      arm_all     <= en_rise;
      disarm_all  <= en_fall;
      cnt_wr_live <= cnt_wr_any && cfg_q[0];
    end
  end

  etc_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cfg_q[0]), .tick_en(tick_en),
    .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi), .wdata(bus_wdata), .value(count)
  );

  etc_status #(.NCH(NCH)) u_stat (
    .clk(clk), .rst_n(rst_n), .en(cfg_q[0]), .flush(en_fall), .evt(ch_evt),
    .wr(stat_wr), .wdata(bus_wdata), .status(status_q), .clr_pulse(status_clr)
  );

  always_comb begin
    case (sel)
      SEL_CAP_LO: bus_rdata = CAP_LO;
      SEL_CAP_HI: bus_rdata = PERIOD_FS;
      SEL_CFG:    bus_rdata = {30'd0, cfg_q};
      SEL_STAT:   bus_rdata = 32'(status_q);
      SEL_CNT_LO: bus_rdata = count[31:0];
      SEL_CNT_HI: bus_rdata = count[63:32];
      SEL_CHAN:   bus_rdata = ch_rdata;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_core_chk.sv
module evt_timer_core_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_en,
  input logic           glb_en,
  input logic           cnt_wr_any,
  input logic [63:0]    count,
  input logic           en_rise,
  input logic           arm_all,
  input logic           disarm_all,
  input logic [NCH-1:0] status,
  input logic [NCH-1:0] status_clr,
  input logic           ch_req,
  input logic [4:0]     ch_idx,
  input logic           cnt_wr_live
);
  assert_cnt_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cnt_wr_any) |=> $stable(count));

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && tick_en && !cnt_wr_any) |=> (count == $past(count) + 64'd1));

  assert_live_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_any && glb_en) |=> cnt_wr_live);

  assert_arm_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (arm_all && glb_en));

  assert_disarm_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_all |-> (status == '0 && !glb_en));

  assert_clr_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr != '0) |-> ((status_clr & ~$past(status)) == '0));

  assert_chan_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_req |-> (int'(ch_idx) < NCH));
endmodule

bind evt_timer_core evt_timer_core_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .glb_en(glb_en),
  .cnt_wr_any(cnt_wr_any), .count(count), .en_rise(en_rise),
  .arm_all(arm_all), .disarm_all(disarm_all), .status(status_q),
  .status_clr(status_clr), .ch_req(ch_req), .ch_idx(ch_idx),
  .cnt_wr_live(cnt_wr_live)
);

// File: tb/evt_timer_core_test.sv
module evt_timer_core_test;
  localparam int          NCH    = 3;
  localparam logic [31:0] PERIOD = 32'd8_000_000;
  // capability low word assembled field by field: id, legacy cap, 64-bit cap, count-1, revision
  localparam logic [31:0] CAP_LO = (32'h5A17 << 16) | (32'h1 << 15) | (32'h1 << 13)
                                 | (32'(NCH - 1) << 8) | 32'h01;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'h000, CAP_LO},        // R4
    '{1'b0, 10'h004, PERIOD},        // R4
    '{1'b1, 10'h000, 32'hFFFFFFFF},
    '{1'b1, 10'h004, 32'h0},
    '{1'b0, 10'h000, CAP_LO},        // R4 write ignored
    '{1'b0, 10'h004, PERIOD},
    '{1'b1, 10'h010, 32'hFFFFFFFE},
    '{1'b0, 10'h010, 32'h00000002},  // R5 only bit1 kept
    '{1'b1, 10'h014, 32'hFFFFFFFF},
    '{1'b0, 10'h014, 32'h0},         // R5
    '{1'b1, 10'h010, 32'h0},
    '{1'b0, 10'h010, 32'h0},
    '{1'b1, 10'h0F0, 32'h89ABCDEF},
    '{1'b1, 10'h0F4, 32'h01234567},
    '{1'b0, 10'h0F0, 32'h89ABCDEF},  // R3
    '{1'b0, 10'h0F4, 32'h01234567},  // R3
    '{1'b1, 10'h050, 32'hFFFFFFFF},
    '{1'b0, 10'h050, 32'h0},         // R10
    '{1'b0, 10'h148, 32'hC0DE0208},  // R8 channel 2 offset 8
    '{1'b0, 10'h160, 32'h0}          // R9 channel 3 absent
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_en = 1'b0;
  logic           bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           ch_req, ch_wr;
  logic [4:0]     ch_idx, ch_off;
  logic [31:0]    ch_wdata, ch_rdata;
  logic [NCH-1:0] ch_evt = '0;
  logic [NCH-1:0] status_clr;
  logic           arm_all, disarm_all, glb_en, legacy_en, cnt_wr_live;
  logic [63:0]    count;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // channel model: echoes the addressed slot
  assign ch_rdata = {16'hC0DE, 3'b0, ch_idx, 3'b0, ch_off};

  evt_timer_core #(.NCH(NCH), .PERIOD_FS(PERIOD)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_req(ch_req), .ch_wr(ch_wr), .ch_idx(ch_idx), .ch_off(ch_off),
    .ch_wdata(ch_wdata), .ch_rdata(ch_rdata), .ch_evt(ch_evt),
    .status_clr(status_clr), .arm_all(arm_all), .disarm_all(disarm_all),
    .glb_en(glb_en), .legacy_en(legacy_en), .count(count),
    .cnt_wr_live(cnt_wr_live)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(tag, 64'(bus_rdata), 64'(exp));
    @(posedge clk); #1 bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 pulses", {arm_all, disarm_all, cnt_wr_live, status_clr}, '0);
    rd(10'h0F0, 32'h0, "R1 cnt lo");
    rd(10'h0F4, 32'h0, "R1 cnt hi");
    rd(10'h010, 32'h0, "R1 cfg");
    rd(10'h020, 32'h0, "R1 status");

    // register table with the counter stopped
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else rd(VEC[i].addr, VEC[i].data, $sformatf("R4/R5/R8/R9/R10 vec %0d", i));
    end

    // R3 write while stopped: no flag
    wr(10'h0F0, 32'hFFFFFFFE);
    chk("R3 no live flag when stopped", 64'(cnt_wr_live), 64'd0);
    wr(10'h0F4, 32'h0);

    // R6 enable rise pulse
    wr(10'h010, 32'h1);
    chk("R6 arm pulse", {arm_all, disarm_all}, 64'b10);
    @(posedge clk); #1;
    chk("R6 arm one cycle", 64'(arm_all), 64'd0);

    // R2 counting with carry into high word
    ticks(5);
    rd(10'h0F0, 32'h3, "R2 cnt lo");
    rd(10'h0F4, 32'h1, "R2 cnt hi carry");

    // R3 write while running: flag and precedence over a tick
    @(negedge clk); tick_en = 1'b1;
    wr(10'h0F0, 32'h10);
    tick_en = 1'b0;
    chk("R3 live flag", 64'(cnt_wr_live), 64'd1);
    rd(10'h0F0, 32'h10, "R3 write beats tick");
    rd(10'h0F4, 32'h1, "R3 other half kept");

    // R7 event capture and selective clear
    @(negedge clk); ch_evt = 3'b101;
    @(posedge clk); #1 ch_evt = '0;
    rd(10'h020, 32'h5, "R7 status set");
    wr(10'h020, 32'h6);
    chk("R7 clear pulse", 64'(status_clr), 64'h4);
    rd(10'h020, 32'h1, "R7 status after clear");

    // R6 disable: pulse, status flushed, counter frozen
    wr(10'h010, 32'h0);
    chk("R6 disarm pulse", {arm_all, disarm_all}, 64'b01);
    rd(10'h020, 32'h0, "R6 status flushed");
    ticks(3);
    rd(10'h0F0, 32'h10, "R2 frozen lo");

    // R7 events ignored while stopped
    @(negedge clk); ch_evt = 3'b111;
    @(posedge clk); #1 ch_evt = '0;
    rd(10'h020, 32'h0, "R7 event dropped when stopped");

    // R8 write forwarding
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 10'h12C; bus_wdata = 32'hA5A5;
    #1;
    chk("R8 fwd req/wr/idx/off", {ch_req, ch_wr, ch_idx, ch_off}, {2'b11, 5'd1, 5'd12});
    chk("R8 fwd data", 64'(ch_wdata), 64'hA5A5);
    // R9 out of range slot
    bus_addr = 10'h1A0;
    #1 chk("R9 no req", 64'(ch_req), 64'd0);
    @(posedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;

    finish_run();
  end
endmodule